// File: doc/BRIEF.md
# DMA Block Transfer Sequencer

This block produces the address and count sequence for a pair of DMA channels working together in block mode. Software programs a source start address and a destination start address, 24 bits each. It also sets a stepping mode for each side, a byte or word beat size, a block size, a block count, and which side acts as the repeating block area. A one-cycle `start` pulse loads all of this. After that, each transfer request moves one whole block. A block is a run of beats, and each beat is offered as a read-from-source / write-to-destination command.

A beat is consumed only when the downstream `accept` input is high. After each accepted beat, each address steps up, steps down or stays put, by 1 for byte beats or 2 for word beats. At the end of every block, the block-area side returns to its start address and the other side keeps running. The block size counter reloads from a holding copy. When the last block completes, `done` pulses once and the sequencer goes idle until it is programmed again.

Top module: `dma_blk_seq`

## Requirements
- R1: After reset, `beat_valid` and `done` are both low.
- R2: A request is ignored while the sequencer is unprogrammed or after a job has finished. No beat appears until a new `start` pulse.
- R3: One request produces exactly one block of `cfg_blk_size` accepted beats. A size of 0 means 256 beats.
- R4: Mode encoding: 2'b01 increments, 2'b10 decrements, and 2'b00 or 2'b11 hold the address fixed. The step is 1 when `cfg_word`=0 and 2 when `cfg_word`=1. Arithmetic wraps modulo 2^24. Each side uses its own mode.
- R5: A beat advances only on a cycle where `beat_valid` and `accept` are both high. While `accept` is low, the addresses and counters hold and the same beat stays offered.
- R6: When `cfg_blk_dst`=0 the source is the block area; when it is 1 the destination is. At each block end, the block-area address returns to its programmed start value, while the other side keeps its stepped value.
- R7: A request that arrives while a block is running is remembered. The next block then starts straight after the current one, with no further request.
- R8: `done` is high for exactly one cycle. That cycle follows the edge that accepts the final beat of the last block. The sequencer then offers no beat.
- R9: `beat_word` shows the programmed beat size whenever a beat is offered.
- R10: The job ends after exactly `cfg_blk_count` blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load configuration and arm the sequencer |
| cfg_src_addr | input | 24 | Source start address |
| cfg_dst_addr | input | 24 | Destination start address |
| cfg_src_mode | input | 2 | Source stepping mode |
| cfg_dst_mode | input | 2 | Destination stepping mode |
| cfg_word | input | 1 | 1 = word beats, 0 = byte beats |
| cfg_blk_dst | input | 1 | 1 = destination is block area, 0 = source |
| cfg_blk_size | input | 8 | Beats per block (0 means 256) |
| cfg_blk_count | input | 16 | Number of blocks in the job |
| req | input | 1 | Transfer request, one block each |
| accept | input | 1 | Downstream takes the offered beat |
| beat_valid | output | 1 | A beat command is offered |
| beat_word | output | 1 | Beat size of the offered command |
| beat_src | output | 24 | Read address of the offered beat |
| beat_dst | output | 24 | Write address of the offered beat |
| done | output | 1 | One-cycle pulse at end of job |

## Verification
The bench uses the default widths: 24-bit addresses, an 8-bit block size and a 16-bit block count. These are the real field widths, so address wrap at 24'hFFFFFF and 24'h000000 can be reached directly. So can the 256-beat block coded as size 0. Short blocks and low block counts keep the randomised jobs small. This lets many stepping-mode, block-area and stall combinations run, and every block boundary is checked against a bench model of the addresses.

// File: rtl/dma_blk_pkg.sv
// Package: shared types for the DMA block transfer sequencer.
// Assumes: the mode encoding is part of the port contract.
package dma_blk_pkg;

    typedef enum logic [1:0] {
        AM_HOLD  = 2'b00,
        AM_INC   = 2'b01,
        AM_DEC   = 2'b10,
        AM_HOLD2 = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_RUN  = 2'b10
    } seq_state_e;

endpackage

// File: rtl/dma_addr_gen.sv
// Module: one address side (source or destination).
// It keeps the running address and the programmed start address.
// It steps the address by 1 or 2 per accepted beat, up or down or not at all.
// On restore it returns the running address to the start address.
// Assumes: restore and step never arrive together with load.
// Restore wins over step.
module dma_addr_gen
    import dma_blk_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start_addr,
    input  logic [1:0]    mode_in,
    input  logic          word_in,
    input  logic          step,
    input  logic          restore,
    output logic [AW-1:0] addr
);
    localparam int PADW = AW - 2;

    logic [AW-1:0] addr_q;
    logic [AW-1:0] base_q;
    addr_mode_e    mode_q;
    logic          word_q;
    logic [AW-1:0] step_amt;

    // Step size: 2 for word beats, 1 for byte beats.
    assign step_amt = {{PADW{1'b0}}, word_q, ~word_q};

    // Running address: load, restore to start, or step per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            base_q <= '0;
            mode_q <= AM_HOLD;
            word_q <= 1'b0;
        end else if (load) begin
            addr_q <= start_addr;
            base_q <= start_addr;
            mode_q <= addr_mode_e'(mode_in);
            word_q <= word_in;
        end else if (restore) begin
            addr_q <= base_q;
        end else if (step) begin
            case (mode_q)
                AM_INC:  addr_q <= addr_q + step_amt;
                AM_DEC:  addr_q <= addr_q - step_amt;
                default: addr_q <= addr_q;
            endcase
        end
    end

    assign addr = addr_q;

    // The address only moves on load, restore or an accepted beat.
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step && !restore) |=> $stable(addr_q));

    // A fixed-mode side never moves between loads unless restored.
    assert_fixed_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !restore && (mode_q == AM_HOLD || mode_q == AM_HOLD2)) |=> $stable(addr_q));

endmodule

// File: rtl/dma_beat_ctr.sv
// Module: block size counter with a holding copy.
// It counts down once per accepted beat and flags the last beat of a block.
// When that last beat is accepted it reloads from the holding copy.
// Assumes: a programmed size of 0 means 2**SW beats (the count wraps).
module dma_beat_ctr #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] size_in,
    input  logic          step,
    output logic          last
);
    localparam logic [SW-1:0] ONE = SW'(1);

    logic [SW-1:0] hold_q;
    logic [SW-1:0] cnt_q;

    // Holding copy is written only by load; the counter reloads from it at block end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            hold_q <= size_in;
            cnt_q  <= size_in;
        end else if (step) begin
            cnt_q <= (cnt_q == ONE) ? hold_q : cnt_q - ONE;
        end
    end

    assign last = (cnt_q == ONE);

    // The count moves only on load or an accepted beat.
    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cnt_q));

    // The holding copy never changes while a job runs.
    assert_hold_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hold_q));

endmodule

// File: rtl/dma_blk_ctrl.sv
// Module: sequencing control.
// It holds the idle / wait-for-request / running state and the block counter.
// It latches requests that arrive during a block and produces the done pulse.
// It also picks which address side is restored at each block end.
// Assumes: last_beat comes from the beat counter in the same cycle.
module dma_blk_ctrl
    import dma_blk_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] blk_count,
    input  logic          blk_dst,
    input  logic          req,
    input  logic          accept,
    input  logic          last_beat,
    output logic          running,
    output logic          beat_fire,
    output logic          restore_src,
    output logic          restore_dst,
    output logic          done
);
    localparam logic [CW-1:0] ONE = CW'(1);

    seq_state_e    state_q;
    logic [CW-1:0] blkcnt_q;
    logic          pend_q;
    logic          done_q;
    logic          blk_dst_q;
    logic          blk_end;
    logic          final_blk;

    // Beat and block events derived from the state and the handshake.
    always_comb begin
        running   = (state_q == ST_RUN);
        beat_fire = running && accept;
        blk_end   = beat_fire && last_beat;
        final_blk = blk_end && (blkcnt_q == ONE);
    end

    // State, block counter, pending request and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            blkcnt_q  <= '0;
            pend_q    <= 1'b0;
            done_q    <= 1'b0;
            blk_dst_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                state_q   <= ST_WAIT;
                blkcnt_q  <= blk_count;
                pend_q    <= 1'b0;
                blk_dst_q <= blk_dst;
            end else begin
                case (state_q)
                    ST_WAIT: if (req) state_q <= ST_RUN;
                    ST_RUN: begin
                        if (blk_end) begin
                            blkcnt_q <= blkcnt_q - ONE;
                            pend_q   <= 1'b0;
                            if (final_blk) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end else if (!(pend_q || req)) begin
                                state_q <= ST_WAIT;
                            end
                        end else if (req) begin
                            pend_q <= 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign restore_src = blk_end && !blk_dst_q;
    assign restore_dst = blk_end && blk_dst_q;
    assign done        = done_q;

    // Done lasts a single cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // Done is only raised once the sequencer has gone idle.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE));

    // Without start, idle is never left, whatever req does.
    assert_idle_ignores_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE));

    // A latched request never survives into the waiting state.
    assert_no_stale_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !pend_q);

endmodule

// File: rtl/dma_blk_seq.sv
// Module: top of the DMA block transfer sequencer.
// It joins two address sides, the beat counter and the control.
// Beat commands are offered on beat_valid and taken on accept.
// Assumes: start may come at any time and restarts the job.
module dma_blk_seq #(
    parameter int AW = 24,
    parameter int SW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cfg_src_addr,
    input  logic [AW-1:0] cfg_dst_addr,
    input  logic [1:0]    cfg_src_mode,
    input  logic [1:0]    cfg_dst_mode,
    input  logic          cfg_word,
    input  logic          cfg_blk_dst,
    input  logic [SW-1:0] cfg_blk_size,
    input  logic [CW-1:0] cfg_blk_count,
    input  logic          req,
    input  logic          accept,
    output logic          beat_valid,
    output logic          beat_word,
    output logic [AW-1:0] beat_src,
    output logic [AW-1:0] beat_dst,
    output logic          done
);
    logic running;
    logic beat_fire;
    logic last_beat;
    logic restore_src;
    logic restore_dst;
    logic word_q;

    // Beat size latched at start for the command output.
    always_ff @(posedge clk) begin
        if (!rst_n)     word_q <= 1'b0;
        else if (start) word_q <= cfg_word;
    end

    dma_blk_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .blk_count(cfg_blk_count), .blk_dst(cfg_blk_dst),
        .req(req), .accept(accept), .last_beat(last_beat),
        .running(running), .beat_fire(beat_fire),
        .restore_src(restore_src), .restore_dst(restore_dst),
        .done(done)
    );

    dma_beat_ctr #(.SW(SW)) u_beats (
        .clk(clk), .rst_n(rst_n), .load(start),
        .size_in(cfg_blk_size), .step(beat_fire), .last(last_beat)
    );

    dma_addr_gen #(.AW(AW)) u_src (
        .clk(clk), .rst_n(rst_n), .load(start),
        .start_addr(cfg_src_addr), .mode_in(cfg_src_mode), .word_in(cfg_word),
        .step(beat_fire), .restore(restore_src), .addr(beat_src)
    );

    dma_addr_gen #(.AW(AW)) u_dst (
        .clk(clk), .rst_n(rst_n), .load(start),
        .start_addr(cfg_dst_addr), .mode_in(cfg_dst_mode), .word_in(cfg_word),
        .step(beat_fire), .restore(restore_dst), .addr(beat_dst)
    );

    assign beat_valid = running;
    assign beat_word  = word_q;

    // A stalled beat stays offered with unchanged addresses.
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !accept && !start) |=> (beat_valid && $stable(beat_src) && $stable(beat_dst)));

    // No beat is offered in the cycle done is shown.
    assert_quiet_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !beat_valid);

endmodule

// File: tb/dma_blk_seq_bench.sv
module dma_blk_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] cfg_src_addr = '0;
    logic [23:0] cfg_dst_addr = '0;
    logic [1:0]  cfg_src_mode = '0;
    logic [1:0]  cfg_dst_mode = '0;
    logic        cfg_word = 1'b0;
    logic        cfg_blk_dst = 1'b0;
    logic [7:0]  cfg_blk_size = '0;
    logic [15:0] cfg_blk_count = '0;
    logic        req = 1'b0;
    logic        accept = 1'b0;
    logic        beat_valid;
    logic        beat_word;
    logic [23:0] beat_src;
    logic [23:0] beat_dst;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_blk_seq u_dma_blk_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_word(cfg_word), .cfg_blk_dst(cfg_blk_dst),
        .cfg_blk_size(cfg_blk_size), .cfg_blk_count(cfg_blk_count),
        .req(req), .accept(accept),
        .beat_valid(beat_valid), .beat_word(beat_word),
        .beat_src(beat_src), .beat_dst(beat_dst), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Next address of one side per the mode and beat size rules.
    function automatic logic [23:0] next_addr(input logic [23:0] a, input logic [1:0] m, input bit w);
        logic [23:0] st;
        st = w ? 24'd2 : 24'd1;
        case (m)
            2'b01:   return a + st;
            2'b10:   return a - st;
            default: return a;
        endcase
    endfunction

    // Idle check: requests for some cycles must not produce a beat or done.
    task automatic idle_probe(input string tag);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            req = 1'b1;
            accept = 1'b1;
            @(negedge clk);
            chk(!beat_valid && !done, tag, {beat_valid, done}, 0);
        end
        req = 1'b0;
    endtask

    // One job; req_mode 0 = random req/accept, 1 = one req at start and one during block 1.
    task automatic run_job(input logic [23:0] s, input logic [23:0] d,
                           input logic [1:0] sm, input logic [1:0] dm,
                           input bit w, input bit bd, input logic [7:0] bs,
                           input logic [15:0] bc, input int req_mode);
        logic [23:0] m_src, m_dst;
        int per_blk, inblk, blocks, beats, cyc;
        bit exp_done, got_done;
        per_blk = (bs == 8'd0) ? 256 : int'(bs);
        m_src = s; m_dst = d;
        inblk = 0; blocks = 0; beats = 0; cyc = 0;
        exp_done = 1'b0; got_done = 1'b0;
        @(negedge clk);
        cfg_src_addr = s; cfg_dst_addr = d; cfg_src_mode = sm; cfg_dst_mode = dm;
        cfg_word = w; cfg_blk_dst = bd; cfg_blk_size = bs; cfg_blk_count = bc;
        req = 1'b0; accept = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!got_done && cyc < 20000) begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            if (exp_done) begin
                chk(done == 1'b1, "R8 done after final beat", done, 1);
                chk(!beat_valid, "R8 idle at done", beat_valid, 0);
                got_done = 1'b1;
            end else begin
                if (done) chk(1'b0, "R10 early done", done, 0);
                if (beat_valid) begin
                    chk(beat_src == m_src, "R4/R5/R6 src", beat_src, m_src);
                    chk(beat_dst == m_dst, "R4/R5/R6 dst", beat_dst, m_dst);
                    chk(beat_word == w, "R9 beat size", beat_word, w);
                end
                if (req_mode == 1) begin
                    req = (cyc == 1) || (beat_valid && blocks == 0 && inblk == 1);
                    accept = 1'b1;
                end else begin
                    req = ($urandom % 3) == 0;
                    accept = ($urandom % 4) != 0;
                end
                if (beat_valid && accept) begin
                    beats++;
                    inblk++;
                    m_src = next_addr(m_src, sm, w);
                    m_dst = next_addr(m_dst, dm, w);
                    if (inblk == per_blk) begin
                        inblk = 0;
                        blocks++;
                        if (bd) m_dst = d; else m_src = s;
                        if (blocks == int'(bc)) exp_done = 1'b1;
                    end
                end
            end
        end
        req = 1'b0; accept = 1'b0;
        chk(got_done, (req_mode == 1) ? "R7 latched request served" : "R10 job completes", got_done, 1);
        chk(beats == per_blk * int'(bc), "R3/R10 beat total", beats, per_blk * int'(bc));
        @(negedge clk);
        chk(!done && !beat_valid, "R8 single done pulse", {done, beat_valid}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!beat_valid && !done, "R1 reset state", {beat_valid, done}, 0);
        idle_probe("R2 req before programming");

        // Pending request: two blocks of three, only one extra request.
        run_job(24'h000100, 24'h000200, 2'b01, 2'b01, 1'b0, 1'b0, 8'd3, 16'd2, 1);
        idle_probe("R2 req after done");

        // Wrap on both sides, word beats, destination is block area.
        run_job(24'hFFFFFE, 24'h000002, 2'b01, 2'b10, 1'b1, 1'b1, 8'd3, 16'd3, 0);
        // 256-beat block coded as size zero.
        run_job(24'h123456, 24'h00ABCD, 2'b11, 2'b01, 1'b0, 1'b0, 8'd0, 16'd1, 0);
        // Fixed both sides, single-beat blocks.
        run_job(24'h0F0F0F, 24'hF0F0F0, 2'b00, 2'b11, 1'b1, 1'b1, 8'd1, 16'd4, 0);

        for (int j = 0; j < 10; j++) begin
            run_job(24'($urandom), 24'($urandom), 2'($urandom), 2'($urandom),
                    1'($urandom), 1'($urandom), 8'(1 + $urandom % 6), 16'(1 + $urandom % 4), 0);
        end
        idle_probe("R2 req after random jobs");

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule